// File: doc/BRIEF.md
# Dual-Half Capture Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves. Each half can run by itself or the two can be chained into one 16-bit channel. A half advances either on ticks from a shared programmable prescaler, which divides the instruction-cycle enable, or on rising edges of an external event input. Each half compares its count against a match register. On a match it reloads to zero and raises its interrupt flag. Two capture-trigger inputs copy the running count into capture registers, and in chained modes both bytes are taken together.

Software drives the block through a plain register write/read port. It sets the mode, the prescale value and the match values, starts and stops counting, and reads counts and captures back. The flags appear directly on two interrupt-request pins and stay set until software clears them. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. A register write takes effect at the clock edge where `reg_we` is high and always completes in that cycle. Reads are combinational.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset every count, capture, match and prescale register reads 0, the block is stopped in mode 0, and both interrupt outputs are low.
- R2: With prescale value P, a prescaled half advances once every P+1 clock edges at which `cyc_en` is high. These edges are counted from the edge where running starts. Edges with `cyc_en` low do not count. Stopping clears the prescaler, so each new run starts a fresh P+1 interval.
- R3: Mode 0 (CTRL mode field 0): both halves are independent 8-bit prescaled timers. A half whose count equals its match value M reloads to 0 on its next advance instead of incrementing. After T advances from zero it therefore holds T mod (M+1). Its flag (low half to `irq_lo`, high half to `irq_hi`) goes high at the first such reload.
- R4: Mode 1 (mode field 1): the low half is an 8-bit prescaled timer and the high half counts rising edges of `evt_in`. The high half reloads against its own match value and sets `irq_hi`.
- R5: Mode 2 (mode field 2): the halves form one 16-bit prescaled timer. The low half carries into the high half when it wraps from 255. The 16-bit count reloads to 0 only when both halves equal {MATCH_HI, MATCH_LO} together, and that reload sets `irq_hi`. `irq_lo` is never set in modes 2 and 3.
- R6: Mode 3 (mode field 3): the halves form one 16-bit counter of `evt_in` rising edges, with the same combined match, reload and `irq_hi` behaviour as R5.
- R7: `evt_in` and the capture inputs pass through two synchronising flops and are acted on at rising edges. A pulse that is high for one enabled cycle and low for one enabled cycle is counted exactly once.
- R8: In modes 0 and 1, a rising edge on `cap_lo_in` copies the low count into CAP_LO and a rising edge on `cap_hi_in` copies the high count into CAP_HI. Neither edge touches the other capture register.
- R9: In modes 2 and 3, a rising edge on `cap_lo_in` copies both count bytes into CAP_LO and CAP_HI at the same edge. A rising edge on `cap_hi_in` changes no capture register.
- R10: While stopped (CTRL bit 0 = 0), both counts hold their values.
- R11: Interrupt flags stay set until a CTRL write with bit 3 = 1 (clears `irq_lo`) or bit 4 = 1 (clears `irq_hi`). Clearing one flag leaves the other unchanged.
- R12: The register map is as follows. Address 0 is CTRL, with bit 0 run and bits 2:1 mode; it reads back as {irq_hi, irq_lo} in bits 4:3, mode in bits 2:1 and run in bit 0. Address 1 is PRESC. Address 2 is MATCH_LO and address 3 is MATCH_HI. Addresses 4 and 5 are CAP_LO and CAP_HI (read only). Addresses 6 and 7 are the low and high counts (read only). Writable registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable; gates prescaler, sync sampling and counting |
| evt_in | input | 1 | External event input |
| cap_lo_in | input | 1 | Capture trigger for the low half (both halves in chained modes) |
| cap_hi_in | input | 1 | Capture trigger for the high half |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_lo | output | 1 | Low-half interrupt flag |
| irq_hi | output | 1 | High-half or 16-bit interrupt flag |

## Verification
The bench sweeps all four modes over several prescale values and run lengths. It predicts each count as the number of enabled edges divided by P+1, reduced modulo the match value plus one. An off-by-one in the prescaler or reload rule would shift every predicted count. It aims at the 16-bit corner where the low byte alone already equals MATCH_LO: a design that reloads per half would wrap early there. It also checks that the low flag never rises in chained modes, and that a stop followed by a restart begins a fresh prescale interval, which a prescaler that is not cleared on stop would cut short. In chained modes it checks that one trigger captures both bytes and that the high trigger is inert; a split capture path would leave a stale byte or overwrite the held value.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT_TMR = 2'd0,
    MODE_TMR_EVT   = 2'd1,
    MODE_WIDE_TMR  = 2'd2,
    MODE_WIDE_EVT  = 2'd3
  } tmr_mode_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_PRESC  = 3'd1;
  localparam logic [2:0] A_MLO    = 3'd2;
  localparam logic [2:0] A_MHI    = 3'd3;
  localparam logic [2:0] A_CAPLO  = 3'd4;
  localparam logic [2:0] A_CAPHI  = 3'd5;
  localparam logic [2:0] A_CNTLO  = 3'd6;
  localparam logic [2:0] A_CNTHI  = 3'd7;

  localparam int CTRL_RUN      = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_CLR_LO   = 3;
  localparam int CTRL_CLR_HI   = 4;

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = active && step && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!active) cnt <= '0;
    else if (step)    cnt <= tick ? '0 : cnt + 1'b1;
  end

  AST_PRESC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0)) else $error("prescaler not cleared"); // R2

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit != '0) |=> (!tick || limit == '0)) else $error("ticks too close"); // R2

endmodule

// File: rtl/dct_edge_sync.sv
module dct_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic rise
);

  logic [SYNC:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh <= '0;
    else if (en) sh <= {sh[SYNC-1:0], din};
  end

  assign rise = sh[SYNC-1] && !sh[SYNC];

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && en) |=> !rise) else $error("edge seen twice"); // R7

endmodule

// File: rtl/dct_count_half.sv
module dct_count_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == '0)) else $error("reload missed"); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload) |=> (cnt == $past(cnt) + 1'b1)) else $error("step wrong"); // R3

endmodule

// File: rtl/dct_capture.sv
module dct_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_CAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))) else $error("capture lost"); // R8

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)) else $error("capture drifted"); // R9

endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer #(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              evt_in,
  input  logic              cap_lo_in,
  input  logic              cap_hi_in,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [HALF_W-1:0] reg_wdata,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  import dct_pkg::*;

  localparam int REG_W  = HALF_W;
  localparam int N_HALF = 2;
  localparam int N_SYNC = 3;

  logic               run_q;
  tmr_mode_e          mode_q;
  logic [PRE_W-1:0]   presc_q;
  logic [HALF_W-1:0]  match_q [N_HALF];
  logic               irq_lo_q, irq_hi_q;

  logic               ctrl_wr;
  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      mode_q     <= MODE_SPLIT_TMR;
      presc_q    <= '0;
      match_q[0] <= '0;
      match_q[1] <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          run_q  <= reg_wdata[CTRL_RUN];
          mode_q <= tmr_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
        end
        A_PRESC: presc_q    <= reg_wdata[PRE_W-1:0];
        A_MLO:   match_q[0] <= reg_wdata;
        A_MHI:   match_q[1] <= reg_wdata;
        default: ;
      endcase
    end
  end

  // input synchronisers: 0 event, 1 low capture, 2 high capture
  logic [N_SYNC-1:0] raw_in, rise;
  assign raw_in = {cap_hi_in, cap_lo_in, evt_in};

  for (genvar s = 0; s < N_SYNC; s++) begin : g_sync
    dct_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .en(cyc_en), .din(raw_in[s]), .rise(rise[s])
    );
  end

  logic tick;
  dct_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .active(run_q), .step(cyc_en),
    .limit(presc_q), .tick(tick)
  );

  logic              wide, evt_step;
  logic              src_lo, src_hi;
  logic              hit_lo, hit_hi, hit_wide;
  logic [N_HALF-1:0] step_v, reload_v, load_v;
  logic [HALF_W-1:0] cnt_v [N_HALF];
  logic [HALF_W-1:0] cap_v [N_HALF];
  logic              set_lo, set_hi;

  assign wide     = mode_q[1];
  assign evt_step = rise[0] && cyc_en && run_q;
  assign hit_lo   = (cnt_v[0] == match_q[0]);
  assign hit_hi   = (cnt_v[1] == match_q[1]);
  assign hit_wide = hit_lo && hit_hi;

  always_comb begin
    src_lo = (mode_q == MODE_WIDE_EVT) ? evt_step : tick;
    case (mode_q)
      MODE_SPLIT_TMR: src_hi = tick;
      MODE_TMR_EVT:   src_hi = evt_step;
      default:        src_hi = src_lo && (cnt_v[0] == {HALF_W{1'b1}});
    endcase
    if (wide) begin
      reload_v[0] = src_lo && hit_wide;
      reload_v[1] = src_lo && hit_wide;
    end else begin
      reload_v[0] = src_lo && hit_lo;
      reload_v[1] = src_hi && hit_hi;
    end
    step_v[0] = src_lo && !reload_v[0];
    step_v[1] = src_hi && !reload_v[1];
    set_lo    = !wide && reload_v[0];
    set_hi    = reload_v[1];
    load_v[0] = rise[1] && cyc_en;
    load_v[1] = wide ? (rise[1] && cyc_en) : (rise[2] && cyc_en);
  end

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    dct_count_half #(.W(HALF_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step_v[h]), .reload(reload_v[h]),
      .cnt(cnt_v[h])
    );
    dct_capture #(.W(HALF_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .load(load_v[h]), .d(cnt_v[h]), .q(cap_v[h])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      if (set_lo)                              irq_lo_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[CTRL_CLR_LO]) irq_lo_q <= 1'b0;
      if (set_hi)                              irq_hi_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[CTRL_CLR_HI]) irq_hi_q <= 1'b0;
    end
  end

  assign irq_lo = irq_lo_q;
  assign irq_hi = irq_hi_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_RUN]             = run_q;
        reg_rdata[CTRL_MODE_LSB +: 2]   = mode_q;
        reg_rdata[CTRL_CLR_LO]          = irq_lo_q;
        reg_rdata[CTRL_CLR_HI]          = irq_hi_q;
      end
      A_PRESC: reg_rdata = REG_W'(presc_q);
      A_MLO:   reg_rdata = match_q[0];
      A_MHI:   reg_rdata = match_q[1];
      A_CAPLO: reg_rdata = cap_v[0];
      A_CAPHI: reg_rdata = cap_v[1];
      A_CNTLO: reg_rdata = cnt_v[0];
      default: reg_rdata = cnt_v[1];
    endcase
  end

  AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> ($stable(cnt_v[0]) && $stable(cnt_v[1]))) else $error("count moved while stopped"); // R10

  AST_NO_LO_FLAG_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && $past(wide)) |-> !$rose(irq_lo_q)) else $error("low flag in chained mode"); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi_q && !(ctrl_wr && reg_wdata[CTRL_CLR_HI])) |=> irq_hi_q) else $error("flag dropped"); // R11

  AST_WIDE_CAPTURE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && rise[1] && cyc_en) |=> (cap_v[0] == $past(cnt_v[0]) && cap_v[1] == $past(cnt_v[1])))
    else $error("chained capture torn"); // R9

endmodule

// File: tb/sim_dual_capture_timer.sv
`timescale 1ns/100ps
module sim_dual_capture_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b1;
  logic       evt_in = 1'b0;
  logic       cap_lo_in = 1'b0;
  logic       cap_hi_in = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_lo, irq_hi;
  logic       gate = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) cyc_en <= gate ? ~cyc_en : 1'b1;

  dual_capture_timer u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_in(evt_in),
    .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input int p, input int ml, input int mh);
    do_reset();
    wr(3'd1, p[7:0]);
    wr(3'd2, ml[7:0]);
    wr(3'd3, mh[7:0]);
  endtask

  // counts exactly k clock edges with run high (k >= 2)
  task automatic run_cycles(input int mode, input int k);
    wr(3'd0, {5'd0, mode[1:0], 1'b1});
    repeat (k - 2) @(negedge clk);
    wr(3'd0, {5'd0, mode[1:0], 1'b0});
  endtask

  // n event pulses, one cycle high and one low; run spans 2n+7 edges
  task automatic run_events(input int mode, input int n);
    wr(3'd0, {5'd0, mode[1:0], 1'b1});
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_in = 1'b1;
      @(negedge clk); evt_in = 1'b0;
    end
    repeat (5) @(negedge clk);
    wr(3'd0, {5'd0, mode[1:0], 1'b0});
  endtask

  task automatic pulse_cap(input bit hi);
    @(negedge clk);
    if (hi) cap_hi_in = 1'b1; else cap_lo_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_hi_in = 1'b0; cap_lo_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, t;
    int ks[4] = '{2, 7, 20, 41};
    do_reset();

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    check("R1 irq_lo after reset", irq_lo, 0);
    check("R1 irq_hi after reset", irq_hi, 0);

    // R12: read-back of writable registers
    wr(3'd1, 8'hA5); rd(3'd1, v); check("R12 PRESC readback", v, 8'hA5);
    wr(3'd2, 8'h3C); rd(3'd2, v); check("R12 MATCH_LO readback", v, 8'h3C);
    wr(3'd3, 8'hC3); rd(3'd3, v); check("R12 MATCH_HI readback", v, 8'hC3);
    wr(3'd0, 8'h06); rd(3'd0, v); check("R12 CTRL readback", v, 8'h06);

    // R2 / R3: mode 0 sweep over prescale values and run lengths
    for (int p = 0; p < 4; p++) begin
      for (int j = 0; j < 4; j++) begin
        setup(p, 5, 9);
        run_cycles(0, ks[j]);
        t = ks[j] / (p + 1);
        rd(3'd6, v); check($sformatf("R2 R3 lo p=%0d k=%0d", p, ks[j]), v, t % 6);
        rd(3'd7, v); check($sformatf("R2 R3 hi p=%0d k=%0d", p, ks[j]), v, t % 10);
        check($sformatf("R3 irq_lo p=%0d k=%0d", p, ks[j]), irq_lo, (t >= 6) ? 1 : 0);
        check($sformatf("R3 irq_hi p=%0d k=%0d", p, ks[j]), irq_hi, (t >= 10) ? 1 : 0);
      end
    end

    // R2: cyc_en low cycles do not count
    setup(0, 200, 200);
    gate = 1'b1;
    run_cycles(0, 40);
    gate = 1'b0;
    rd(3'd6, v); check("R2 gated enable p=0", v, 20);
    setup(1, 200, 200);
    gate = 1'b1;
    run_cycles(0, 40);
    gate = 1'b0;
    rd(3'd6, v); check("R2 gated enable p=1", v, 10);

    // R2: stop clears the prescaler
    setup(3, 200, 200);
    run_cycles(0, 6);
    run_cycles(0, 6);
    rd(3'd6, v); check("R2 prescaler restart", v, 2);
    // R10: stopped count holds
    repeat (20) @(negedge clk);
    rd(3'd6, v); check("R10 stopped count holds", v, 2);

    // R4 / R7: mode 1
    for (int n = 2; n <= 5; n++) begin
      setup(1, 200, 2);
      run_events(1, n);
      rd(3'd7, v); check($sformatf("R4 R7 event count n=%0d", n), v, n % 3);
      check($sformatf("R4 irq_hi n=%0d", n), irq_hi, (n >= 3) ? 1 : 0);
      rd(3'd6, v); check($sformatf("R4 timer lo n=%0d", n), v, (2 * n + 7) / 2);
      check($sformatf("R4 irq_lo n=%0d", n), irq_lo, 0);
    end

    // R5: mode 2, combined match 260 with low byte matching early
    begin
      int kk[5] = '{258, 260, 261, 262, 300};
      for (int j = 0; j < 5; j++) begin
        setup(0, 4, 1);
        run_cycles(2, kk[j]);
        t = kk[j] % 261;
        rd(3'd6, v); check($sformatf("R5 wide lo k=%0d", kk[j]), v, t % 256);
        rd(3'd7, v); check($sformatf("R5 wide hi k=%0d", kk[j]), v, t / 256);
        check($sformatf("R5 irq_hi k=%0d", kk[j]), irq_hi, (kk[j] >= 261) ? 1 : 0);
        check($sformatf("R5 irq_lo k=%0d", kk[j]), irq_lo, 0);
      end
    end
    setup(1, 4, 1);
    run_cycles(2, 600);
    rd(3'd6, v); check("R5 wide p=1 lo", v, (300 % 261) % 256);
    rd(3'd7, v); check("R5 wide p=1 hi", v, (300 % 261) / 256);

    // R6: mode 3
    for (int n = 2; n <= 4; n++) begin
      setup(0, 3, 0);
      run_events(3, n);
      rd(3'd6, v); check($sformatf("R6 wide events n=%0d", n), v, n % 4);
      check($sformatf("R6 irq_hi n=%0d", n), irq_hi, (n >= 4) ? 1 : 0);
    end
    setup(0, 2, 1);
    run_events(3, 257);
    rd(3'd6, v); check("R6 257 events lo", v, 1);
    rd(3'd7, v); check("R6 257 events hi", v, 1);
    check("R6 257 events no irq", irq_hi, 0);
    setup(0, 2, 1);
    run_events(3, 260);
    rd(3'd6, v); check("R6 260 events lo", v, 1);
    rd(3'd7, v); check("R6 260 events hi", v, 0);
    check("R6 260 events irq_hi", irq_hi, 1);
    check("R6 260 events irq_lo", irq_lo, 0);

    // R11: flags sticky, cleared separately
    setup(0, 2, 3);
    run_cycles(0, 10);
    check("R11 both flags set lo", irq_lo, 1);
    check("R11 both flags set hi", irq_hi, 1);
    repeat (10) @(negedge clk);
    check("R11 lo stays set", irq_lo, 1);
    wr(3'd0, 8'h08);
    check("R11 lo cleared", irq_lo, 0);
    check("R11 hi kept", irq_hi, 1);
    wr(3'd0, 8'h10);
    check("R11 hi cleared", irq_hi, 0);

    // R8: split captures
    setup(0, 10, 60);
    run_cycles(0, 23);
    pulse_cap(1'b0);
    rd(3'd4, v); check("R8 cap_lo takes low count", v, 1);
    rd(3'd5, v); check("R8 cap_hi untouched", v, 0);
    pulse_cap(1'b1);
    rd(3'd5, v); check("R8 cap_hi takes high count", v, 23);
    rd(3'd4, v); check("R8 cap_lo untouched", v, 1);

    // R9: chained captures
    setup(0, 0, 2);
    run_cycles(2, 300);
    pulse_cap(1'b0);
    rd(3'd4, v); check("R9 wide cap lo byte", v, 300 % 256);
    rd(3'd5, v); check("R9 wide cap hi byte", v, 300 / 256);
    run_cycles(2, 10);
    pulse_cap(1'b1);
    rd(3'd4, v); check("R9 hi trigger ignored lo", v, 300 % 256);
    rd(3'd5, v); check("R9 hi trigger ignored hi", v, 300 / 256);
    pulse_cap(1'b0);
    rd(3'd4, v); check("R9 recapture lo", v, 310 % 256);
    rd(3'd5, v); check("R9 recapture hi", v, 310 / 256);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule